// File: doc/BRIEF.md
# Event-Based Branch Control Unit

This block gives user-level software a fast path from a hardware event to a handler routine on a 64-bit processor. It keeps three 64-bit registers: a status/control word, a return-address register and a handler-address register. Software reads and writes them through a simple register port. Two event lines come in, one from an external source and one from the performance monitor. The current next-instruction address comes in as well. When an event arrives and is enabled, the block asks the pipeline in the same cycle to redirect fetch to the handler address. It also saves the return address and turns off further branching.

The handler finishes with a return-from-event-branch instruction. The block decodes that instruction word itself. It sets or clears the global enable from the instruction's S bit and redirects fetch back to the saved address, which is shaped for 64-bit or 32-bit mode. If a reserved field of the status word is non-zero, the block rejects the return and flags an invalid instruction form instead.

Bit numbers in the requirements use big-endian numbering: bit 0 is the most significant bit and bit 63 the least significant bit of a 64-bit value.

Top module: `ebb_ctrl_unit`

## Requirements
- R1: After a synchronous active-low reset, all three registers read zero, no redirect is requested and the invalid-form flag is low.
- R2: An external event (ext_evt_i) causes a branch only when status bit 0 (global enable) and status bit 30 (external enable) are both 1. A performance-monitor event (pm_evt_i) causes a branch only when bit 0 and bit 31 (monitor enable) are both 1. Events that are not enabled have no effect on outputs or registers.
- R3: In the cycle a branch is taken, redirect_valid_o is 1 and redirect_target_o equals the handler register. From the next cycle on, status bit 0 reads 0.
- R4: A taken branch loads bits 0-61 of the return register from bits 0-61 of nia_i. Bits 62-63 of the return register are left unchanged.
- R5: A taken branch sets status bit 62 for an enabled external event and status bit 63 for an enabled monitor event. These bits stay set until software writes the status register.
- R6: When both enabled sources fire in the same cycle, redirect_cause_o reports external (code 1) and both occurred bits are set. A monitor-only branch reports code 2, a return reports code 3, and no redirect reports code 0.
- R7: A return is recognised only when insn_valid_i is 1, insn_i[31:26] = 010011 and insn_i[10:1] = 0010010010. S is insn_i[11]. Any other word has no effect.
- R8: An accepted return requests a redirect with cause 3, and from the next cycle status bit 0 equals S.
- R9: With msr_sf_i = 1, the return target is return-register bits 0-61 followed by 00. With msr_sf_i = 0, it is 32 zero bits, then return-register bits 32-61, then 00.
- R10: If status bits 32:33 are not 00 when a return is recognised, inval_form_o is 1 for that cycle, no redirect is requested and no register changes.
- R11: A register write (wr_sel_i: 0 status, 1 return, 2 handler, 3 none) is visible on the next cycle. If a branch happens in the same cycle, the branch's updates win for the bits it modifies, and the written value lands in every other bit. An accepted return in the same cycle overrides the written bit 0.
- R12: When a branch and a return occur in the same cycle, the branch is taken and the return is dropped: no invalid flag is raised and S is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_evt_i | input | 1 | External event request |
| pm_evt_i | input | 1 | Performance-monitor event request |
| nia_i | input | 64 | Address of the next instruction |
| msr_sf_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| insn_valid_i | input | 1 | insn_i holds an instruction being executed |
| insn_i | input | 32 | Instruction word |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 status, 1 return, 2 handler |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as wr_sel_i |
| rd_data_o | output | 64 | Selected register value (combinational) |
| redirect_valid_o | output | 1 | Fetch redirect request |
| redirect_target_o | output | 64 | Redirect address |
| redirect_cause_o | output | 2 | 0 none, 1 external, 2 monitor, 3 return |
| inval_form_o | output | 1 | Return rejected as an invalid form |

## Verification
The hardest cases to reach are collisions inside a single cycle: an event taken while software writes a register, and an event arriving together with a return. In normal use these are rare. The bench first arms the enables, then raises the event line in the exact cycle the write strobe or the return instruction is applied. It then reads back the merged register contents bit by bit. The enable gating is swept over all 32 combinations of the three enables and two event lines. The return path is swept over S, the mode flag, all four reserved-field values and two corrupted encodings.

// File: rtl/ebb_pkg.sv
// Package: shared constants and types for the event-based branch unit.
// Assumes 64-bit registers; architectural bit k (big-endian) maps to
// vector index XLEN-1-k.
package ebb_pkg;
    parameter int XLEN   = 64;
    parameter int INSN_W = 32;
    localparam int HALF  = XLEN / 2;

    localparam int BIT_GE      = XLEN - 1 - 0;
    localparam int BIT_EXT_EN  = XLEN - 1 - 30;
    localparam int BIT_PM_EN   = XLEN - 1 - 31;
    localparam int BIT_RSV_HI  = XLEN - 1 - 32;
    localparam int BIT_RSV_LO  = XLEN - 1 - 33;
    localparam int BIT_EXT_OCC = XLEN - 1 - 62;
    localparam int BIT_PM_OCC  = XLEN - 1 - 63;

    localparam logic [5:0] OPC_PRIMARY  = 6'b010011;
    localparam logic [9:0] OPC_EXTENDED = 10'b0010010010;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_EXT  = 2'd1,
        CAUSE_PM   = 2'd2,
        CAUSE_RET  = 2'd3
    } ebb_cause_e;

    typedef enum logic [1:0] {
        SEL_STATUS  = 2'd0,
        SEL_RETURN  = 2'd1,
        SEL_HANDLER = 2'd2,
        SEL_NONE    = 2'd3
    } ebb_sel_e;
endpackage

// File: rtl/ebb_event_gate.sv
// Module: ebb_event_gate
// Qualifies the two event lines with the global and per-source enables and
// picks the reported cause (external beats monitor). Purely combinational;
// clk/rst_n serve only the embedded assertions.
module ebb_event_gate
    import ebb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ge,
    input  logic       en_ext,
    input  logic       en_pm,
    input  logic       ext_evt,
    input  logic       pm_evt,
    output logic       hit_ext,
    output logic       hit_pm,
    output logic       take,
    output ebb_cause_e cause
);
    // Qualify each source and select a cause with external priority.
    always_comb begin
        hit_ext = ge && en_ext && ext_evt;
        hit_pm  = ge && en_pm && pm_evt;
        take    = hit_ext || hit_pm;
        if (hit_ext)     cause = CAUSE_EXT;
        else if (hit_pm) cause = CAUSE_PM;
        else             cause = CAUSE_NONE;
    end

    AST_TAKE_NEEDS_GE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ge); // R2
    AST_EXT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_evt && pm_evt && take && en_ext) |-> cause == CAUSE_EXT); // R6
    AST_PM_ONLY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_evt && !ext_evt && take) |-> cause == CAUSE_PM); // R6
endmodule

// File: rtl/ebb_return_unit.sv
// Module: ebb_return_unit
// Decodes the return-from-event-branch word, checks the reserved status
// field and forms the return target for 64-bit or 32-bit mode.
// Assumes 'blocked' is high whenever a branch is taken in the same cycle.
module ebb_return_unit
    import ebb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic              sf,
    input  logic [1:0]        rsv,
    input  logic [XLEN-1:0]   ebbrr,
    input  logic              blocked,
    output logic              ret_fire,
    output logic              ret_s,
    output logic              inval,
    output logic [XLEN-1:0]   target
);
    logic is_ret;
    logic unused_bits;

    assign unused_bits = ^{insn[25:12], insn[0], ebbrr[1:0]};

    // Match the fixed opcode fields and split accept from reject.
    always_comb begin
        is_ret   = insn_valid && (insn[31:26] == OPC_PRIMARY)
                   && (insn[10:1] == OPC_EXTENDED);
        ret_s    = insn[11];
        ret_fire = is_ret && !blocked && (rsv == 2'b00);
        inval    = is_ret && !blocked && (rsv != 2'b00);
    end

    // Build the word-aligned return address for the current mode.
    always_comb begin
        target = '0;
        if (sf) target[XLEN-1:2] = ebbrr[XLEN-1:2];
        else    target[HALF-1:2] = ebbrr[HALF-1:2];
    end

    AST_RET_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_fire && !sf) |-> (target[XLEN-1:HALF] == '0)); // R9
    AST_RET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |-> (target[1:0] == 2'b00)); // R9
    AST_RET_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |-> (!ret_fire && !inval)); // R12
endmodule

// File: rtl/ebb_ctrl_unit.sv
// Module: ebb_ctrl_unit (top)
// Holds the status, return and handler registers, merges software writes
// with branch and return updates, and drives the fetch redirect.
// Assumes one software write per cycle; reads are combinational.
module ebb_ctrl_unit
    import ebb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_evt_i,
    input  logic              pm_evt_i,
    input  logic [XLEN-1:0]   nia_i,
    input  logic              msr_sf_i,
    input  logic              insn_valid_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [XLEN-1:0]   wr_data_i,
    input  logic [1:0]        rd_sel_i,
    output logic [XLEN-1:0]   rd_data_o,
    output logic              redirect_valid_o,
    output logic [XLEN-1:0]   redirect_target_o,
    output logic [1:0]        redirect_cause_o,
    output logic              inval_form_o
);
    logic [XLEN-1:0] bescr_q, ebbrr_q, ebbhr_q;
    logic [XLEN-1:0] bescr_d, ebbrr_d, ebbhr_d;
    logic            hit_ext, hit_pm, take;
    ebb_cause_e      evt_cause;
    logic            ret_fire, ret_s, ret_inval;
    logic [XLEN-1:0] ret_target;
    logic            unused_nia;

    assign unused_nia = ^nia_i[1:0];

    ebb_event_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .ge      (bescr_q[BIT_GE]),
        .en_ext  (bescr_q[BIT_EXT_EN]),
        .en_pm   (bescr_q[BIT_PM_EN]),
        .ext_evt (ext_evt_i),
        .pm_evt  (pm_evt_i),
        .hit_ext (hit_ext),
        .hit_pm  (hit_pm),
        .take    (take),
        .cause   (evt_cause)
    );

    ebb_return_unit u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_valid (insn_valid_i),
        .insn       (insn_i),
        .sf         (msr_sf_i),
        .rsv        (bescr_q[BIT_RSV_HI:BIT_RSV_LO]),
        .ebbrr      (ebbrr_q),
        .blocked    (take),
        .ret_fire   (ret_fire),
        .ret_s      (ret_s),
        .inval      (ret_inval),
        .target     (ret_target)
    );

    // Next-state merge: software write first, then return, then branch.
    always_comb begin
        bescr_d = bescr_q;
        ebbrr_d = ebbrr_q;
        ebbhr_d = ebbhr_q;
        if (wr_en_i) begin
            case (wr_sel_i)
                SEL_STATUS:  bescr_d = wr_data_i;
                SEL_RETURN:  ebbrr_d = wr_data_i;
                SEL_HANDLER: ebbhr_d = wr_data_i;
                default:     ;
            endcase
        end
        if (ret_fire) bescr_d[BIT_GE] = ret_s;
        if (take) begin
            bescr_d[BIT_GE]      = 1'b0;
            ebbrr_d[XLEN-1:2]    = nia_i[XLEN-1:2];
            if (hit_ext) bescr_d[BIT_EXT_OCC] = 1'b1;
            if (hit_pm)  bescr_d[BIT_PM_OCC]  = 1'b1;
        end
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bescr_q <= '0;
            ebbrr_q <= '0;
            ebbhr_q <= '0;
        end else begin
            bescr_q <= bescr_d;
            ebbrr_q <= ebbrr_d;
            ebbhr_q <= ebbhr_d;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (rd_sel_i)
            SEL_STATUS:  rd_data_o = bescr_q;
            SEL_RETURN:  rd_data_o = ebbrr_q;
            SEL_HANDLER: rd_data_o = ebbhr_q;
            default:     rd_data_o = '0;
        endcase
    end

    // Redirect request and cause selection.
    always_comb begin
        redirect_valid_o  = take || ret_fire;
        redirect_target_o = take ? ebbhr_q : ret_target;
        if (take)          redirect_cause_o = evt_cause;
        else if (ret_fire) redirect_cause_o = CAUSE_RET;
        else               redirect_cause_o = CAUSE_NONE;
        inval_form_o = ret_inval;
    end

    AST_GE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !bescr_q[BIT_GE]); // R3
    AST_RR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (ebbrr_q[XLEN-1:2] == $past(nia_i[XLEN-1:2]))); // R4
    AST_OCC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i == SEL_STATUS) |=>
        ((bescr_q[BIT_EXT_OCC:BIT_PM_OCC] & $past(bescr_q[BIT_EXT_OCC:BIT_PM_OCC]))
          == $past(bescr_q[BIT_EXT_OCC:BIT_PM_OCC]))); // R5
    AST_RET_SETS_GE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_fire |=> (bescr_q[BIT_GE] == $past(ret_s))); // R8
    AST_INVAL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_form_o && !wr_en_i) |=>
        ($stable(bescr_q) && $stable(ebbrr_q) && $stable(ebbhr_q))); // R10
    AST_HANDLER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_HANDLER) |=> (ebbhr_q == $past(wr_data_i))); // R11
endmodule

// File: tb/sim_ebb_ctrl_unit.sv
module sim_ebb_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_evt_i = 1'b0, pm_evt_i = 1'b0;
    logic [63:0] nia_i = '0;
    logic        msr_sf_i = 1'b1;
    logic        insn_valid_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [63:0] wr_data_i = '0;
    logic [1:0]  rd_sel_i = '0;
    logic [63:0] rd_data_o;
    logic        redirect_valid_o;
    logic [63:0] redirect_target_o;
    logic [1:0]  redirect_cause_o;
    logic        inval_form_o;

    int nchk = 0;
    int nfail = 0;

    localparam logic [63:0] M_GE   = 64'h1 << 63;
    localparam logic [63:0] M_EE   = 64'h1 << 33;
    localparam logic [63:0] M_PE   = 64'h1 << 32;
    localparam logic [63:0] M_EOCC = 64'h1 << 1;
    localparam logic [63:0] M_POCC = 64'h1;

    ebb_ctrl_unit u0 (
        .clk(clk), .rst_n(rst_n), .ext_evt_i(ext_evt_i), .pm_evt_i(pm_evt_i),
        .nia_i(nia_i), .msr_sf_i(msr_sf_i), .insn_valid_i(insn_valid_i),
        .insn_i(insn_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
        .redirect_valid_o(redirect_valid_o), .redirect_target_o(redirect_target_o),
        .redirect_cause_o(redirect_cause_o), .inval_form_o(inval_form_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [63:0] d);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
        step();
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [63:0] v);
        rd_sel_i = sel;
        #1;
        v = rd_data_o;
    endtask

    function automatic logic [31:0] mk_ret(input logic s, input int bad);
        logic [31:0] w;
        w = {6'b010011, 14'h2A5, s, 10'b0010010010, 1'b1};
        if (bad == 1) w[29] = ~w[29];
        if (bad == 2) w[4]  = ~w[4];
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [63:0] v, bes, hh, rr, nn, exp_b, exp_r, exp_t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, v); chk("R1 status", v, 0);
        rd(1, v); chk("R1 return", v, 0);
        rd(2, v); chk("R1 handler", v, 0);
        chk("R1 redirect", {63'b0, redirect_valid_o}, 0);
        chk("R1 inval", {63'b0, inval_form_o}, 0);

        // R2/R3/R4/R5/R6 sweep of enables and event lines
        for (int i = 0; i < 32; i++) begin
            logic ge, ee, pe, xe, pv, he, hp;
            ge = i[0]; ee = i[1]; pe = i[2]; xe = i[3]; pv = i[4];
            bes = (ge ? M_GE : 0) | (ee ? M_EE : 0) | (pe ? M_PE : 0);
            hh  = 64'hC0DE_0000_0000_1000 + 64'(i * 16);
            rr  = 64'h0F0F_0000_5555_0001 ^ (64'(i) << 40);
            nn  = 64'h1234_5678_9ABC_DEF3 ^ (64'(i) << 8);
            wr(0, bes); wr(2, hh); wr(1, rr);
            he = ge & ee & xe; hp = ge & pe & pv;
            ext_evt_i = xe; pm_evt_i = pv; nia_i = nn;
            #1;
            chk("R2 redirect gating", {63'b0, redirect_valid_o}, {63'b0, he | hp});
            chk("R6 cause", {62'b0, redirect_cause_o},
                {62'b0, he ? 2'd1 : (hp ? 2'd2 : 2'd0)});
            if (he | hp) chk("R3 target is handler", redirect_target_o, hh);
            step();
            ext_evt_i = 1'b0; pm_evt_i = 1'b0;
            exp_b = bes;
            if (he | hp) exp_b = exp_b & ~M_GE;
            if (he) exp_b = exp_b | M_EOCC;
            if (hp) exp_b = exp_b | M_POCC;
            rd(0, v); chk("R3 R5 status after event", v, exp_b);
            exp_r = (he | hp) ? {nn[63:2], rr[1:0]} : rr;
            rd(1, v); chk("R4 return capture", v, exp_r);
        end

        // R5 sticky occurred bits, cleared only by a write
        wr(0, M_GE | M_EE | M_PE);
        ext_evt_i = 1; pm_evt_i = 1; step(); ext_evt_i = 0; pm_evt_i = 0;
        repeat (5) step();
        rd(0, v); chk("R5 sticky", v, M_EE | M_PE | M_EOCC | M_POCC);
        wr(0, 0);
        rd(0, v); chk("R5 cleared by write", v, 0);

        // R7/R8/R9/R10 return sweep
        for (int s = 0; s < 2; s++)
            for (int sf = 0; sf < 2; sf++)
                for (int rsv = 0; rsv < 4; rsv++)
                    for (int bad = 0; bad < 3; bad++) begin
                        logic good;
                        good = (bad == 0);
                        bes = (s == 0 ? M_GE : 0) | (64'(rsv) << 30) | M_EOCC;
                        rr  = 64'hFEDC_BA98_7654_3211 ^ (64'(rsv) << 12);
                        wr(0, bes); wr(1, rr);
                        msr_sf_i = sf[0]; insn_i = mk_ret(s[0], bad); insn_valid_i = 1;
                        #1;
                        chk("R10 inval flag", {63'b0, inval_form_o},
                            {63'b0, good && rsv != 0});
                        chk("R7 R8 redirect", {63'b0, redirect_valid_o},
                            {63'b0, good && rsv == 0});
                        if (good && rsv == 0) begin
                            chk("R8 cause", {62'b0, redirect_cause_o}, 3);
                            exp_t = sf ? {rr[63:2], 2'b00} : {32'b0, rr[31:2], 2'b00};
                            chk("R9 target", redirect_target_o, exp_t);
                        end
                        step();
                        insn_valid_i = 0;
                        exp_b = bes;
                        if (good && rsv == 0) exp_b = s ? (bes | M_GE) : (bes & ~M_GE);
                        rd(0, v); chk("R7 R8 R10 status", v, exp_b);
                        rd(1, v); chk("R10 return unchanged", v, rr);
                    end
        msr_sf_i = 1;

        // R11 write and branch in the same cycle (status)
        wr(2, 64'hAAAA_0000_0000_0040);
        wr(0, M_GE | M_EE);
        nn = 64'h0000_7777_0000_1238; nia_i = nn; ext_evt_i = 1;
        wr(0, M_GE | M_EE | M_PE);
        ext_evt_i = 0;
        rd(0, v); chk("R11 status merge", v, M_EE | M_PE | M_EOCC);
        // R11 write and branch in the same cycle (return register)
        wr(0, M_GE | M_EE);
        ext_evt_i = 1; nn = 64'h5555_0000_3333_000C; nia_i = nn;
        wr(1, 64'h0123_4567_89AB_CDE3);
        ext_evt_i = 0;
        rd(1, v); chk("R11 return merge", v, {nn[63:2], 2'b11});
        // R11 write of the handler register
        wr(2, 64'h0000_0000_DEAD_BEEC);
        rd(2, v); chk("R11 handler write", v, 64'h0000_0000_DEAD_BEEC);
        // R11 return overrides written global enable
        wr(0, M_PE);
        insn_i = mk_ret(1'b1, 0); insn_valid_i = 1;
        wr(0, M_EE);
        insn_valid_i = 0;
        rd(0, v); chk("R11 return beats write", v, M_GE | M_EE);

        // R12 branch and return in the same cycle
        wr(0, M_GE | M_EE);
        ext_evt_i = 1; insn_i = mk_ret(1'b1, 0); insn_valid_i = 1;
        #1;
        chk("R12 cause external", {62'b0, redirect_cause_o}, 1);
        chk("R12 target handler", redirect_target_o, 64'h0000_0000_DEAD_BEEC);
        chk("R12 no inval", {63'b0, inval_form_o}, 0);
        step();
        ext_evt_i = 0; insn_valid_i = 0;
        rd(0, v); chk("R12 enable cleared", v, M_EE | M_EOCC);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule